// File: doc/BRIEF.md
# Two-Dimensional Strided Beat Address Generator

This block turns one transfer descriptor into the stream of beat addresses that a copy engine needs on its read side and its write side. The descriptor holds a source base, a destination base, a row size in bytes, a row count, one stride per side and a repeat flag. Row sizes and row counts are written as the true value minus one. The generator walks the rows one after another. Inside a row, both addresses step by the bus width on every accepted beat. Each new row starts at the previous row start plus that side's stride.

A consumer takes the current pair of addresses whenever `ready` is high. While `ready` is low, the walk holds where it is. A single row (row count field 0) gives a plain linear transfer. In repeat mode, the walk goes back to the two bases after the final beat and does not stop. This suits ring buffers that a peripheral streams into without pause. In normal mode, the block raises a one-cycle completion pulse and returns to idle.

Top module: `stride2d_agen`

## Requirements
- R1: After reset, `busy`, `last` and `done` are 0.
- R2: A `start` pulse while idle loads the descriptor. In the next cycle `busy` is 1 and `src_addr`/`dst_addr` equal the two bases.
- R3: Each cycle with `busy` and `ready` high that is not the last beat of a row advances both addresses by 4 (the bus width in bytes).
- R4: While `ready` is low, both addresses and `busy` keep their values.
- R5: After the last beat of row r, the addresses become base plus (r+1) times the stride of each side. The source stride and the destination stride act independently.
- R6: A row holds (x_len_m1+1)/4 beats and a transfer holds y_len_m1+1 rows, so y_len_m1 = 0 gives a one-row transfer. `last` is 1 exactly while the final beat of the final row is offered.
- R7: In normal mode, `done` is high for exactly one cycle right after the final beat is accepted. In that same cycle `busy` has dropped to 0.
- R8: In repeat mode, the beat after the final beat starts again at both bases, `busy` stays 1 and `done` never rises.
- R9: `start` while `busy` is high has no effect on the addresses of the running walk.
- R10: A stride smaller than the row size is not rejected. Rows then overlap exactly as programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load descriptor and begin (taken only when idle) |
| src_base | input | ADDR_W | Source base address |
| dst_base | input | ADDR_W | Destination base address |
| x_len_m1 | input | LEN_W | Bytes per row minus one |
| y_len_m1 | input | LEN_W | Rows minus one |
| src_stride | input | ADDR_W | Source row-to-row distance in bytes |
| dst_stride | input | ADDR_W | Destination row-to-row distance in bytes |
| cyclic | input | 1 | Repeat the walk forever |
| ready | input | 1 | Consumer accepts the current beat |
| busy | output | 1 | A walk is in progress; addresses are valid |
| src_addr | output | ADDR_W | Current source beat address |
| dst_addr | output | ADDR_W | Current destination beat address |
| last | output | 1 | Current beat is the final one of the transfer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The walk is tried with five patterns, and each separates a different fault:
- A single-row linear transfer isolates the column step and the completion pulse.
- A three-row walk with unequal source and destination strides, under a ready pattern that stalls every other cycle, tells a wrong side's stride apart from a missed hold.
- A stride shorter than the row shows that overlapping rows are followed rather than clamped.
- A repeat-mode walk, run past two full passes, exposes a wrap that restarts from the wrong row start or that leaks a completion pulse.
- A start issued mid-walk with a different base shows whether a busy generator reloads.

// File: rtl/stride2d_agen.sv
module stride2d_agen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [LEN_W-1:0]  x_len_m1,
  input  logic [LEN_W-1:0]  y_len_m1,
  input  logic [ADDR_W-1:0] src_stride,
  input  logic [ADDR_W-1:0] dst_stride,
  input  logic              cyclic,
  input  logic              ready,
  output logic              busy,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              last,
  output logic              done
);
  localparam int CW = LEN_W + 1;
  localparam logic [CW-1:0]     XSTEP = CW'(BEAT_BYTES);
  localparam logic [ADDR_W-1:0] ASTEP = ADDR_W'(BEAT_BYTES);

  logic              busy_q, cyc_q, done_q;
  logic [LEN_W-1:0]  xlen_q, ylen_q, xcnt_q, ycnt_q;
  logic [ADDR_W-1:0] sstr_q, dstr_q, sbase_q, dbase_q;
  logic [ADDR_W-1:0] srow_q, drow_q, scur_q, dcur_q;

  logic col_end, row_end;
  assign col_end = ({1'b0, xcnt_q} + XSTEP) > {1'b0, xlen_q};
  assign row_end = (ycnt_q == ylen_q);

  assign busy     = busy_q;
  assign src_addr = scur_q;
  assign dst_addr = dcur_q;
  assign last     = busy_q && col_end && row_end;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cyc_q   <= 1'b0;
      done_q  <= 1'b0;
      xlen_q  <= '0;
      ylen_q  <= '0;
      xcnt_q  <= '0;
      ycnt_q  <= '0;
      sstr_q  <= '0;
      dstr_q  <= '0;
      sbase_q <= '0;
      dbase_q <= '0;
      srow_q  <= '0;
      drow_q  <= '0;
      scur_q  <= '0;
      dcur_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          cyc_q   <= cyclic;
          xlen_q  <= x_len_m1;
          ylen_q  <= y_len_m1;
          sstr_q  <= src_stride;
          dstr_q  <= dst_stride;
          sbase_q <= src_base;
          dbase_q <= dst_base;
          srow_q  <= src_base;
          drow_q  <= dst_base;
          scur_q  <= src_base;
          dcur_q  <= dst_base;
          xcnt_q  <= '0;
          ycnt_q  <= '0;
        end
      end else if (ready) begin
        if (!col_end) begin
          xcnt_q <= xcnt_q + LEN_W'(BEAT_BYTES);
          scur_q <= scur_q + ASTEP;
          dcur_q <= dcur_q + ASTEP;
        end else if (!row_end) begin
          xcnt_q <= '0;
          ycnt_q <= ycnt_q + 1'b1;
          srow_q <= srow_q + sstr_q;
          drow_q <= drow_q + dstr_q;
          scur_q <= srow_q + sstr_q;
          dcur_q <= drow_q + dstr_q;
        end else begin
          xcnt_q <= '0;
          ycnt_q <= '0;
          srow_q <= sbase_q;
          drow_q <= dbase_q;
          scur_q <= sbase_q;
          dcur_q <= dbase_q;
          if (!cyc_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stride2d_agen_chk.sv
module stride2d_agen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ready,
  input logic              busy,
  input logic              done,
  input logic              cyc_q,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr
);
  a_r2_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ready) |=> (busy && $stable(src_addr) && $stable(dst_addr)));

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_no_done_in_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cyc_q);

  a_r9_busy_start_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ready && start) |=> $stable(src_addr));
endmodule

bind stride2d_agen stride2d_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .busy(busy_q),
  .done(done_q), .cyc_q(cyc_q), .src_addr(scur_q), .dst_addr(dcur_q)
);

// File: tb/stride2d_agen_tb.sv
module stride2d_agen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0, src_stride = '0, dst_stride = '0;
  logic [15:0] x_len_m1 = '0, y_len_m1 = '0;
  logic        cyclic = 1'b0, ready = 1'b0;
  logic        busy, last, done;
  logic [31:0] src_addr, dst_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  stride2d_agen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
    .x_len_m1(x_len_m1), .y_len_m1(y_len_m1), .src_stride(src_stride),
    .dst_stride(dst_stride), .cyclic(cyclic), .ready(ready), .busy(busy),
    .src_addr(src_addr), .dst_addr(dst_addr), .last(last), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; ready = 1'b0;
    @(negedge clk); @(negedge clk);
    check(busy == 1'b0, "R1 busy", 64'(busy), 0);
    check(done == 1'b0, "R1 done", 64'(done), 0);
    check(last == 1'b0, "R1 last", 64'(last), 0);
    rst_n = 1'b1;
  endtask

  task automatic run(input logic [31:0] sb, input logic [31:0] db, input logic [15:0] xm1,
                     input logic [15:0] ym1, input logic [31:0] ss, input logic [31:0] ds,
                     input bit cyc, input int rmode, input int nbeats, input bit poke,
                     input string tag);
    int nb = (int'(xm1) + 1) / 4;
    int r = 0, c = 0, cnt = 0, k = 0;
    bit rdy;
    logic [31:0] es, ed;
    @(negedge clk);
    src_base = sb; dst_base = db; x_len_m1 = xm1; y_len_m1 = ym1;
    src_stride = ss; dst_stride = ds; cyclic = cyc; start = 1'b1; ready = 1'b0;
    while (cnt < nbeats) begin
      @(negedge clk);
      start = 1'b0;
      es = sb + 32'(r) * ss + 32'(c * 4);
      ed = db + 32'(r) * ds + 32'(c * 4);
      check(busy == 1'b1, {"R2 busy ", tag}, 64'(busy), 1);
      check(src_addr == es, {"R3 R4 R5 src ", tag}, 64'(src_addr), 64'(es));
      check(dst_addr == ed, {"R3 R4 R5 dst ", tag}, 64'(dst_addr), 64'(ed));
      check(last == (r == int'(ym1) && c == nb - 1), {"R6 last ", tag}, 64'(last),
            64'(r == int'(ym1) && c == nb - 1));
      check(done == 1'b0, {"R7 R8 no early done ", tag}, 64'(done), 0);
      case (rmode)
        1: rdy = (k % 2 == 0);
        2: rdy = (k % 3 != 2);
        default: rdy = 1'b1;
      endcase
      if (poke && k == 1) begin
        start = 1'b1;
        src_base = 32'hDEAD_0000;
        dst_base = 32'hBEEF_0000;
      end
      k++;
      ready = rdy;
      @(posedge clk);
      if (rdy) begin
        cnt++;
        if (c == nb - 1) begin
          c = 0;
          r = (r == int'(ym1)) ? 0 : r + 1;
        end else c++;
      end
    end
    @(negedge clk);
    start = 1'b0; ready = 1'b0;
    if (!cyc) begin
      check(done == 1'b1, {"R7 done pulse ", tag}, 64'(done), 1);
      check(busy == 1'b0, {"R7 busy dropped ", tag}, 64'(busy), 0);
      @(negedge clk);
      check(done == 1'b0, {"R7 done one cycle ", tag}, 64'(done), 0);
    end else begin
      check(busy == 1'b1, "R8 stays busy", 64'(busy), 1);
      check(done == 1'b0, "R8 no done", 64'(done), 0);
      check(src_addr == sb, "R8 src wrap to base", 64'(src_addr), 64'(sb));
      check(dst_addr == db, "R8 dst wrap to base", 64'(dst_addr), 64'(db));
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R6: one-row linear transfer, 4 beats
    run(32'h1000, 32'h8000, 16'd15, 16'd0, 32'h0, 32'h0, 1'b0, 0, 4, 1'b0, "R6 1d");
    // R5: three rows, independent strides, stalls
    run(32'h2000, 32'h9000, 16'd11, 16'd2, 32'h100, 32'h40, 1'b0, 1, 9, 1'b0, "R5 2d");
    // R10: stride smaller than row
    run(32'h3000, 32'hA000, 16'd15, 16'd3, 32'h8, 32'h4, 1'b0, 2, 16, 1'b0, "R10 overlap");
    // R9: start while busy ignored
    run(32'h4000, 32'hB000, 16'd7, 16'd1, 32'h20, 32'h30, 1'b0, 1, 4, 1'b1, "R9 busy start");
    // R8: repeat mode, two full passes
    run(32'h5000, 32'hC000, 16'd7, 16'd2, 32'h80, 32'h10, 1'b1, 0, 12, 1'b0, "R8 repeat");
    do_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule